// File: doc/BRIEF.md
# PIPE Receiver Detect Sequencer

This block sits on the PHY side of a PIPE-style link and answers the MAC's request to check whether a far-end receiver is attached. The MAC places the power-state input in P1 and raises the detect request. The block then arms an abstracted line-sense circuit for a settle window whose length is a parameter. At the last cycle of that window it samples the sense result once. It reports the outcome as a one-cycle done strobe with a 3-bit status code.

A request made in any other power state is ignored. An attempt stops without a report if the request falls or the power state leaves P1 while it is running. After each attempt, whether it completed or was aborted, the request must be seen low before a new attempt is taken. There is no data stream, so every pin is a plain control or status level with no handshake. The analog sense circuit is outside the block; the bench models it as a driven input.

Top module: `rxdet_seq`

## Requirements
- R1: A synchronous active-high reset, held for one clock, sets sense_arm, phy_done and phy_status to zero in the next cycle. It also abandons any running attempt and allows a new request to be taken.
- R2: An attempt starts only when pwr_state equals 2'b10 (P1) and det_req is high. With any other pwr_state value, det_req has no effect: sense_arm and phy_done stay low.
- R3: After the clock edge that accepts a request, sense_arm is high for exactly SETTLE consecutive cycles (default 16). No attempt starts while sense_arm is high.
- R4: A completed attempt gives exactly one phy_done cycle, in the cycle right after the last sense_arm cycle. line_sense is sampled only in that last sense_arm cycle; its value earlier in the window has no effect.
- R5: phy_status in the phy_done cycle is 3'b011 when the sampled line_sense was high.
- R6: phy_status in the phy_done cycle is 3'b000 when the sampled line_sense was low.
- R7: phy_status reads 3'b000 whenever phy_done is low.
- R8: If det_req is low, or pwr_state is not 2'b10, in any sense_arm cycle, the attempt aborts. sense_arm is low from the next cycle and no phy_done follows for that attempt.
- R9: After an attempt is accepted, no further attempt starts until det_req has been sampled low. Holding det_req high, or coming back into P1 with det_req still high after an abort, starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_state | input | 2 | Power state from the MAC; 2'b10 is P1 |
| det_req | input | 1 | Detect/loopback request from the MAC |
| line_sense | input | 1 | Result of the line-sense circuit; high means a receiver is present |
| sense_arm | output | 1 | High while the settle window runs and the sense circuit is armed |
| phy_done | output | 1 | One-cycle completion strobe |
| phy_status | output | 3 | Status code, valid with phy_done: 3'b011 detected, 3'b000 not detected |

## Verification
A fault in the settle counter changes how many cycles sense_arm stays high. That shows at the port when the window closes, no later than SETTLE cycles after acceptance. A fault in the request-qualification state shows within one cycle as a spurious sense_arm rise, for example outside P1 or while det_req is still held high after an attempt. A lost abort shows as a phy_done pulse where none is due. A fault in the sampling or result register shows in the single phy_done cycle as a wrong status code, or as a status that stays nonzero afterwards.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_SETTLE = 1'b1
  } rxdet_state_e;

  localparam logic [1:0] PWR_P1       = 2'b10;
  localparam logic [2:0] STAT_FOUND   = 3'b011;
  localparam logic [2:0] STAT_NONE    = 3'b000;

endpackage

// File: rtl/rxdet_gate.sv
module rxdet_gate
  import rxdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwr_state,
  input  logic       det_req,
  input  logic       accept,
  output logic       qualify,
  output logic       armed
);

  assign qualify = (pwr_state == PWR_P1) && det_req;

  // request must be seen low again before the next attempt
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
    end else if (accept) begin
      armed <= 1'b0;
    end else if (!det_req) begin
      armed <= 1'b1;
    end
  end

endmodule

// File: rtl/rxdet_timer.sv
module rxdet_timer #(
  parameter int SETTLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);

  localparam int CW = (SETTLE > 2) ? $clog2(SETTLE) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && (cnt == CW'(SETTLE - 1));

endmodule

// File: rtl/rxdet_report.sv
module rxdet_report
  import rxdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       sense,
  output logic       done,
  output logic [2:0] status
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      status <= STAT_NONE;
    end else begin
      done   <= fire;
      status <= (fire && sense) ? STAT_FOUND : STAT_NONE;
    end
  end

endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq
  import rxdet_pkg::*;
#(
  parameter int SETTLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwr_state,
  input  logic       det_req,
  input  logic       line_sense,
  output logic       sense_arm,
  output logic       phy_done,
  output logic [2:0] phy_status
);

  rxdet_state_e state, state_nx;
  logic qualify, armed, accept, expire, fire;

  rxdet_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .pwr_state (pwr_state),
    .det_req   (det_req),
    .accept    (accept),
    .qualify   (qualify),
    .armed     (armed)
  );

  rxdet_timer #(.SETTLE(SETTLE)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (state == ST_IDLE),
    .run    ((state == ST_SETTLE) && qualify),
    .expire (expire)
  );

  always_comb begin
    state_nx = state;
    accept   = 1'b0;
    fire     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (qualify && armed) begin
          accept   = 1'b1;
          state_nx = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (!qualify) begin
          state_nx = ST_IDLE;
        end else if (expire) begin
          fire     = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  assign sense_arm = (state == ST_SETTLE);

  rxdet_report u_report (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .sense  (line_sense),
    .done   (phy_done),
    .status (phy_status)
  );

endmodule

// File: rtl/rxdet_seq_chk.sv
module rxdet_seq_chk #(
  parameter int SETTLE = 16
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] pwr_state,
  input logic       det_req,
  input logic       line_sense,
  input logic       sense_arm,
  input logic       phy_done,
  input logic [2:0] phy_status
);

  int arm_run;
  logic live;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_run <= 0;
      live    <= 1'b1;
    end else begin
      arm_run <= sense_arm ? arm_run + 1 : 0;
    end
  end

  // R1: reset clears outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sense_arm && !phy_done && phy_status == 3'b000));

  // R2: nothing starts outside P1
  a_r2_ignore_outside_p1: assert property (@(posedge clk) disable iff (rst)
    (!sense_arm && pwr_state != 2'b10) |=> !sense_arm);

  // R3: window never overruns
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
    live |-> arm_run <= SETTLE);

  // R3/R4: done follows exactly a full window
  a_r4_full_window: assert property (@(posedge clk) disable iff (rst)
    (live && phy_done) |-> (arm_run == SETTLE && !sense_arm));

  // R4: single-cycle strobe
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    phy_done |=> !phy_done);

  // R5/R6: only the two legal codes with done
  a_r5_legal_code: assert property (@(posedge clk) disable iff (rst)
    phy_done |-> (phy_status == 3'b011 || phy_status == 3'b000));

  // R7: quiet status without done
  a_r7_status_quiet: assert property (@(posedge clk) disable iff (rst)
    !phy_done |-> phy_status == 3'b000);

  // R8: abort on request drop or P1 exit
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    (sense_arm && !(det_req && pwr_state == 2'b10)) |=> (!sense_arm && !phy_done));

  // R9: no restart while request held high after done
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (phy_done && det_req) |=> !sense_arm);

endmodule

bind rxdet_seq rxdet_seq_chk #(.SETTLE(SETTLE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_state  (pwr_state),
  .det_req    (det_req),
  .line_sense (line_sense),
  .sense_arm  (sense_arm),
  .phy_done   (phy_done),
  .phy_status (phy_status)
);

// File: tb/sim_rxdet_seq.sv
`timescale 1ns/1ps
module sim_rxdet_seq;

  localparam int SETTLE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pwr_state = 2'b00;
  logic       det_req = 1'b0;
  logic       line_sense = 1'b0;
  logic       sense_arm, phy_done;
  logic [2:0] phy_status;

  int tests = 0;
  int fails = 0;
  int done_seen = 0;
  logic [2:0] last_stat = 3'b000;
  string cur_req = "R1";

  // behavioural reference state
  bit m_busy, m_armed, m_done, m_q;
  int m_cnt;
  logic [2:0] m_stat;

  always #4 clk = ~clk;

  rxdet_seq #(.SETTLE(SETTLE)) u0 (
    .clk(clk), .rst(rst), .pwr_state(pwr_state), .det_req(det_req),
    .line_sense(line_sense), .sense_arm(sense_arm),
    .phy_done(phy_done), .phy_status(phy_status)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_armed = 1; m_done = 0; m_stat = 3'b000;
    end else begin
      m_q = (pwr_state == 2'b10) && det_req;
      m_done = 0; m_stat = 3'b000;
      if (m_busy) begin
        if (!m_q) m_busy = 0;
        else begin
          m_cnt = m_cnt + 1;
          if (m_cnt == SETTLE) begin
            m_busy = 0; m_done = 1;
            m_stat = line_sense ? 3'b011 : 3'b000;
          end
        end
      end else if (m_q && m_armed) begin
        m_busy = 1; m_cnt = 0; m_armed = 0;
      end
      if (!det_req) m_armed = 1;
    end
  end

  // per-cycle compare, away from the active edge
  always @(negedge clk) begin
    if (!rst || cur_req == "R1") begin
      tests++;
      if (sense_arm !== m_busy || phy_done !== m_done || phy_status !== m_stat) begin
        fails++;
        $display("FAIL %s: arm/done/status actual %b/%b/%b expected %b/%b/%b",
                 cur_req, sense_arm, phy_done, phy_status, m_busy, m_done, m_stat);
      end
    end
    if (phy_done === 1'b1) begin
      done_seen++;
      last_stat = phy_status;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d0;
    cur_req = "R1";
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1", {29'd0, phy_status} + phy_done + sense_arm, 0);

    // R2: request outside P1 ignored
    cur_req = "R2";
    d0 = done_seen;
    for (int p = 0; p < 4; p++) begin
      if (p == 2) continue;
      pwr_state = 2'(p); det_req = 1'b1;
      cyc(SETTLE + 6);
      chk("R2", int'(sense_arm), 0);
      det_req = 1'b0; cyc(2);
    end
    chk("R2", done_seen - d0, 0);

    // R5: detected
    cur_req = "R5";
    pwr_state = 2'b10; line_sense = 1'b1; d0 = done_seen;
    det_req = 1'b1;
    cyc(2);
    chk("R3", int'(sense_arm), 1);
    cyc(SETTLE + 2);
    chk("R5", done_seen - d0, 1);
    chk("R5", int'(last_stat), 3);
    // R9: held request, no restart
    cur_req = "R9";
    d0 = done_seen;
    cyc(3 * SETTLE);
    chk("R9", done_seen - d0, 0);
    chk("R9", int'(sense_arm), 0);
    det_req = 1'b0; cyc(2);

    // R6: not detected
    cur_req = "R6";
    line_sense = 1'b0; d0 = done_seen;
    det_req = 1'b1; cyc(SETTLE + 4);
    chk("R6", done_seen - d0, 1);
    chk("R6", int'(last_stat), 0);
    det_req = 1'b0; cyc(2);

    // R4: only last window cycle sampled
    cur_req = "R4";
    d0 = done_seen;
    det_req = 1'b1; line_sense = 1'b1;
    cyc(SETTLE);          // last arm cycle is now current
    line_sense = 1'b0;
    cyc(4);
    chk("R4", done_seen - d0, 1);
    chk("R4", int'(last_stat), 0);
    det_req = 1'b0; cyc(2);
    d0 = done_seen;
    det_req = 1'b1; line_sense = 1'b0;
    cyc(SETTLE);
    line_sense = 1'b1;
    cyc(1);
    line_sense = 1'b0;
    cyc(3);
    chk("R4", int'(last_stat), 3);
    det_req = 1'b0; cyc(2);

    // R8: abort by request drop
    cur_req = "R8";
    d0 = done_seen; line_sense = 1'b1;
    det_req = 1'b1; cyc(5);
    det_req = 1'b0; cyc(1);
    chk("R8", int'(sense_arm), 0);
    cyc(SETTLE + 4);
    chk("R8", done_seen - d0, 0);

    // R8: abort by leaving P1, R9: no retry with request still high
    det_req = 1'b1; cyc(6);
    pwr_state = 2'b11; cyc(3);
    pwr_state = 2'b10; cur_req = "R9";
    cyc(SETTLE + 6);
    chk("R8", done_seen - d0, 0);
    chk("R9", int'(sense_arm), 0);
    det_req = 1'b0; cyc(1);
    det_req = 1'b1; cyc(SETTLE + 3);
    chk("R9", done_seen - d0, 1);
    det_req = 1'b0; cyc(2);

    // R1: reset mid attempt
    cur_req = "R1";
    d0 = done_seen;
    det_req = 1'b1; cyc(7);
    rst = 1'b1; cyc(1);
    rst = 1'b0; det_req = 1'b0;
    chk("R1", int'(sense_arm), 0);
    cyc(SETTLE + 4);
    chk("R1", done_seen - d0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule